// File: doc/BRIEF.md
# 32-bit Integer ALU

This is a purely combinational arithmetic logic unit for a simple load/store integer datapath. It takes two 32-bit operands and a 3-bit operation code. It returns a 32-bit result and three flags. The zero flag is high when the result is all zeros. The signed overflow flag is reported only; it never traps. The carry flag is the carry out of the adder's top bit.

It offers five operations: bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than. One adder serves add, subtract and compare. For subtract and compare, operand B is inverted and the carry into bit 0 is forced to one. The zero flag after a subtraction therefore acts as an equality test for branch decisions.

Top module: `int_alu`

## Requirements
- R1: Opcode 3'b000 returns the bitwise AND of the two operands.
- R2: Opcode 3'b001 returns the bitwise OR of the two operands.
- R3: Opcode 3'b010 returns the operands' sum modulo 2^32. The carry flag equals the unsigned carry out of bit 31.
- R4: On opcode 3'b010, the overflow flag is high exactly when both operands have the same sign and the sum has the other sign. Operands of opposite sign never set it.
- R5: Opcode 3'b110 returns A + ~B + 1, that is A − B modulo 2^32. The carry flag is high exactly when A ≥ B read as unsigned numbers.
- R6: On opcode 3'b110, the overflow flag is high exactly when the true signed difference A − B falls outside the 32-bit signed range.
- R7: Opcode 3'b111 puts 1 in result bit 0 when A < B as signed numbers and 0 otherwise. Bits 31..1 are zero. The answer is correct even when A − B overflows.
- R8: The zero flag is high exactly when all 32 result bits are 0. Under subtract, this means A equals B.
- R9: Under AND, OR and set-on-less-than, the overflow and carry flags are 0.
- R10: The unused opcodes 3'b011, 3'b100 and 3'b101 give a result of zero with overflow and carry cleared, so the zero flag is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation select |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| res_o | output | 32 | Result |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow of add or subtract |
| cout_o | output | 1 | Carry out of bit 31 for add or subtract |

## Verification
The hardest case to reach is a signed compare whose internal difference overflows. In that case the sign of the raw difference gives the wrong answer, and only the overflow correction makes it right. The stimulus targets it with operand pairs at the edges of the signed range, such as the most negative value against a positive value, or the most positive value against a negative value. The same extreme pairs are sent through add and subtract, so that the overflow and carry flags are seen to change at exactly the wrap boundaries.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int WIDTH = 32
) (
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             cout_o
);
  localparam int MSB = WIDTH - 1;
  localparam logic [2:0] OP_AND = 3'b000;
  localparam logic [2:0] OP_OR  = 3'b001;
  localparam logic [2:0] OP_ADD = 3'b010;
  localparam logic [2:0] OP_SUB = 3'b110;
  localparam logic [2:0] OP_SLT = 3'b111;

  logic             b_neg;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   add_full;
  logic [WIDTH-1:0] sum;
  logic             carry_msb;
  logic             ovf_raw;
  logic             less;

  assign b_neg     = op_i[2];
  assign b_eff     = b_neg ? ~b_i : b_i;
  assign add_full  = {1'b0, a_i} + {1'b0, b_eff} + (WIDTH+1)'(b_neg);
  assign sum       = add_full[MSB:0];
  assign carry_msb = add_full[WIDTH];
  assign ovf_raw   = (a_i[MSB] == b_eff[MSB]) && (sum[MSB] != a_i[MSB]);
  assign less      = sum[MSB] ^ ovf_raw;

  always_comb begin
    res_o  = '0;
    ovf_o  = 1'b0;
    cout_o = 1'b0;
    case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_ADD, OP_SUB: begin
        res_o  = sum;
        ovf_o  = ovf_raw;
        cout_o = carry_msb;
      end
      OP_SLT: res_o = {{(WIDTH-1){1'b0}}, less};
      default: res_o = '0;
    endcase
  end

  assign zero_o = ~|res_o;

  always_comb begin
    if (op_i == OP_ADD)
      p_add_sum_r3: assert (res_o == a_i + b_i);
    if (op_i == OP_SUB)
      p_sub_eq_r8: assert (zero_o == (a_i == b_i));
    if (op_i == OP_SUB)
      p_sub_carry_r5: assert (cout_o == (a_i >= b_i));
    if (op_i == OP_SLT)
      p_slt_r7: assert (res_o == WIDTH'($signed(a_i) < $signed(b_i)));
    if (op_i == OP_AND || op_i == OP_OR || op_i == OP_SLT)
      p_no_flags_r9: assert (!ovf_o && !cout_o);
    if (op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101)
      p_unused_r10: assert (zero_o && !ovf_o && !cout_o);
    if (op_i == OP_ADD && (a_i[MSB] != b_i[MSB]))
      p_mixed_sign_r4: assert (!ovf_o);
  end
endmodule

// File: tb/test_int_alu.sv
module test_int_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op;
  logic [31:0] a, b;
  logic [31:0] res;
  logic        zero, ovf, cout;
  int          n_run = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  int_alu i_int_alu (
    .op_i(op), .a_i(a), .b_i(b),
    .res_o(res), .zero_o(zero), .ovf_o(ovf), .cout_o(cout)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    op = o; a = x; b = y;
    @(posedge clk);
    #2;
  endtask

  task automatic run_add(input logic [31:0] x, input logic [31:0] y);
    logic [32:0] w;
    longint s;
    w = {1'b0, x} + {1'b0, y};
    s = longint'($signed(x)) + longint'($signed(y));
    drive(3'b010, x, y);
    chk("R3", "sum", res, w[31:0]);
    chk("R3", "carry", {31'b0, cout}, {31'b0, w[32]});
    chk("R4", "ovf", {31'b0, ovf}, {31'b0, (s > 64'sd2147483647 || s < -64'sd2147483648)});
    chk("R8", "zero", {31'b0, zero}, {31'b0, w[31:0] == 0});
  endtask

  task automatic run_sub(input logic [31:0] x, input logic [31:0] y);
    longint s;
    s = longint'($signed(x)) - longint'($signed(y));
    drive(3'b110, x, y);
    chk("R5", "diff", res, x - y);
    chk("R5", "carry", {31'b0, cout}, {31'b0, x >= y});
    chk("R6", "ovf", {31'b0, ovf}, {31'b0, (s > 64'sd2147483647 || s < -64'sd2147483648)});
    chk("R8", "zero", {31'b0, zero}, {31'b0, x == y});
  endtask

  task automatic run_slt(input logic [31:0] x, input logic [31:0] y);
    drive(3'b111, x, y);
    chk("R7", "less", res, {31'b0, $signed(x) < $signed(y)});
    chk("R9", "flags", {30'b0, ovf, cout}, 32'd0);
  endtask

  task automatic run_logic(input logic [31:0] x, input logic [31:0] y);
    drive(3'b000, x, y);
    chk("R1", "and", res, x & y);
    chk("R9", "and flags", {30'b0, ovf, cout}, 32'd0);
    drive(3'b001, x, y);
    chk("R2", "or", res, x | y);
    chk("R9", "or flags", {30'b0, ovf, cout}, 32'd0);
  endtask

  task automatic run_unused();
    for (int k = 3; k <= 5; k++) begin
      drive(3'(k), 32'hFFFF_FFFF, 32'h8000_0001);
      chk("R10", "result", res, 32'd0);
      chk("R10", "flags", {29'b0, zero, ovf, cout}, 32'd4);
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    op = 3'b000; a = '0; b = '0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    #2;
    chk("R8", "reset zero", {31'b0, zero}, 32'd1);
    chk("R1", "reset res", res, 32'd0);

    run_logic(32'hF0F0_1234, 32'h0FF0_FF00);
    run_logic(32'h0000_0000, 32'hFFFF_FFFF);
    run_add(32'd5, 32'd7);
    run_add(32'h7FFF_FFFF, 32'd1);
    run_add(32'h8000_0000, 32'h8000_0000);
    run_add(32'hFFFF_FFFF, 32'd1);
    run_add(32'h7FFF_FFFF, 32'h8000_0000);
    run_sub(32'd9, 32'd9);
    run_sub(32'd3, 32'd10);
    run_sub(32'h8000_0000, 32'd1);
    run_sub(32'h7FFF_FFFF, 32'hFFFF_FFFF);
    run_sub(32'hFFFF_FFFF, 32'h7FFF_FFFF);
    run_slt(32'd3, 32'd10);
    run_slt(32'd10, 32'd3);
    run_slt(32'hFFFF_FFFE, 32'd1);
    run_slt(32'h8000_0000, 32'h7FFF_FFFF);
    run_slt(32'h7FFF_FFFF, 32'h8000_0000);
    run_slt(32'd4, 32'd4);
    run_unused();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule